// File: doc/BRIEF.md
# Boot Overlay Address Decoder

This block decodes the address of a 32-bit processor bus into three chip selects: one for the boot ROM, one for DRAM and one for a small I/O region at the very top of the address space. After reset it runs in overlay mode. In that mode every address below the top 32 KiB selects the ROM, so the processor can fetch its reset vectors and early code from address zero.

A single strobed access to the trigger address 0xFFFF8000 ends overlay mode. It does not matter whether that access is a read or a write. The decoder then uses the normal map: DRAM sits at zero up to a configurable size, the ROM appears only in the 16 MiB window starting at 0xFE000000, and the top 32 KiB still go to the I/O region. The mode flag is sticky until the next reset and is visible on a status output.

The ROM holds 512 KiB, so only the low 19 address bits are passed to it. It repeats through whatever range selects it.

Top module: `boot_remap_decoder`

## Requirements
- R1: While reset is held low, and after it is released, `map_normal` reads 0 (overlay mode) until a trigger access occurs.
- R2: In overlay mode, a strobed access to any address from 0x00000000 to 0xFFFF7FFF asserts `cs_rom` and no other select.
- R3: In overlay mode `cs_dram` is never asserted, including at address 0x00000000.
- R4: A strobed access to exactly 0xFFFF8000, with `bus_read` either 1 (read) or 0 (write), sets `map_normal` to 1 at the next rising clock edge. An unstrobed access to that address, or a strobed access to any other address, does not set it.
- R5: Once `map_normal` is 1, it stays 1 whatever the later accesses are, until reset is asserted.
- R6: In normal mode, a strobed access asserts `cs_rom` exactly for addresses 0xFE000000 to 0xFEFFFFFF.
- R7: In normal mode, a strobed access asserts `cs_dram` exactly for addresses below `DRAM_BYTES`.
- R8: In both modes, a strobed access to 0xFFFF8000–0xFFFFFFFF asserts `cs_io` alone.
- R9: With `bus_strobe` low, no select is asserted.
- R10: `rom_addr` equals address bits 18:0 while `cs_rom` is high, so the ROM image repeats every 512 KiB, and it is zero otherwise.
- R11: At most one of `cs_rom`, `cs_dram`, `cs_io` is high in any cycle.
- R12: In normal mode, a strobed access that falls in none of the three regions asserts no select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset; returns the decoder to overlay mode |
| bus_addr | input | 32 | Byte address of the current access |
| bus_strobe | input | 1 | High while the address is valid for an access |
| bus_read | input | 1 | 1 = read, 0 = write |
| cs_rom | output | 1 | Boot ROM select |
| cs_dram | output | 1 | DRAM select |
| cs_io | output | 1 | Top-of-memory I/O region select |
| rom_addr | output | 19 | Address bits presented to the ROM |
| map_normal | output | 1 | 0 = overlay mode, 1 = normal map |

## Verification
The bench builds the decoder with `DRAM_BYTES` set to 8 MiB instead of the default 16 MiB. This shows that the size parameter really moves the DRAM boundary. It also leaves a wide unmapped gap between DRAM and the ROM window, so random addresses land there often and exercise the no-select case. Both trigger directions stay enabled, so the bench can leave overlay mode once with a write and, after a second reset, once with a read. Directed addresses sit on either side of each boundary: the DRAM limit, both ends of the ROM window, and the start of the top 32 KiB.

// File: rtl/boot_remap_pkg.sv
// Package: shared region type and fixed address constants of the boot
// overlay decoder. Assumes a 32-bit byte-addressed bus.
package boot_remap_pkg;

    localparam int          ADDR_W       = 32;
    localparam int          ROM_AW       = 19;              // 512 KiB device
    localparam int          IO_LOW_BITS  = 15;              // 32 KiB I/O block
    localparam logic [31:0] IO_BASE      = 32'hFFFF_8000;
    localparam logic [31:0] TRIGGER_ADDR = 32'hFFFF_8000;
    localparam int          ROM_WIN_BITS = 24;              // 16 MiB window
    localparam logic [31:0] ROM_WIN_BASE = 32'hFE00_0000;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_ROM  = 2'd1,
        RG_DRAM = 2'd2,
        RG_IO   = 2'd3
    } region_e;

endpackage

// File: rtl/boot_remap_mode_flag.sv
// Module: sticky overlay-exit flag.
// Sets on the first clock edge that sees a strobed access to the trigger
// address with an enabled direction. Clears only on synchronous reset.
module boot_remap_mode_flag
    import boot_remap_pkg::*;
#(
    parameter bit TRIG_ON_READ  = 1'b1,
    parameter bit TRIG_ON_WRITE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe,
    input  logic              is_read,
    output logic              normal
);

    logic dir_ok;
    logic hit;

    // Qualify the direction of the access against the enabled trigger kinds.
    always_comb begin
        dir_ok = (is_read && TRIG_ON_READ) || (!is_read && TRIG_ON_WRITE);
        hit    = strobe && dir_ok && (addr == TRIGGER_ADDR);
    end

    // Hold the mode; once set it stays set until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            normal <= 1'b0;
        end else if (hit) begin
            normal <= 1'b1;
        end
    end

endmodule

// File: rtl/boot_remap_region.sv
// Module: combinational region classifier.
// Maps an address and the current mode onto one region. The top block is
// tested first, so it never falls into ROM or DRAM. Assumes DRAM_BYTES
// lies below the ROM window.
module boot_remap_region
    import boot_remap_pkg::*;
#(
    parameter logic [31:0] DRAM_BYTES = 32'h0100_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              normal,
    output region_e           region
);

    localparam int IO_TAG_W  = ADDR_W - IO_LOW_BITS;
    localparam int ROM_TAG_W = ADDR_W - ROM_WIN_BITS;
    localparam logic [IO_TAG_W-1:0]  IO_TAG  = IO_BASE[ADDR_W-1:IO_LOW_BITS];
    localparam logic [ROM_TAG_W-1:0] ROM_TAG = ROM_WIN_BASE[ADDR_W-1:ROM_WIN_BITS];

    logic in_io;
    logic in_rom_win;
    logic in_dram;

    // Window membership tests.
    always_comb begin
        in_io      = (addr[ADDR_W-1:IO_LOW_BITS] == IO_TAG);
        in_rom_win = (addr[ADDR_W-1:ROM_WIN_BITS] == ROM_TAG);
        in_dram    = (addr < DRAM_BYTES);
    end

    // Priority choice: I/O first, then the mode-dependent map.
    always_comb begin
        if (in_io) begin
            region = RG_IO;
        end else if (!normal) begin
            region = RG_ROM;
        end else if (in_rom_win) begin
            region = RG_ROM;
        end else if (in_dram) begin
            region = RG_DRAM;
        end else begin
            region = RG_NONE;
        end
    end

endmodule

// File: rtl/boot_remap_selects.sv
// Module: select generator.
// Turns a region code into one-hot selects gated by the address strobe and
// passes the low ROM address bits only while the ROM is selected.
module boot_remap_selects
    import boot_remap_pkg::*;
(
    input  region_e           region,
    input  logic              strobe,
    input  logic [ROM_AW-1:0] low_addr,
    output logic              sel_rom,
    output logic              sel_dram,
    output logic              sel_io,
    output logic [ROM_AW-1:0] rom_addr
);

    // Decode the region into strobe-gated selects.
    always_comb begin
        sel_rom  = strobe && (region == RG_ROM);
        sel_dram = strobe && (region == RG_DRAM);
        sel_io   = strobe && (region == RG_IO);
    end

    // Forward the ROM address only while the ROM is selected.
    always_comb begin
        rom_addr = sel_rom ? low_addr : '0;
    end

endmodule

// File: rtl/boot_remap_decoder.sv
// Module: top of the boot overlay address decoder.
// Selects are combinational in the address of the current cycle. The mode
// changes at the clock edge after a trigger access. Assumes DRAM_BYTES is
// at most 128 MiB.
module boot_remap_decoder
    import boot_remap_pkg::*;
#(
    parameter logic [31:0] DRAM_BYTES    = 32'h0100_0000,
    parameter bit          TRIG_ON_READ  = 1'b1,
    parameter bit          TRIG_ON_WRITE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_addr,
    input  logic        bus_strobe,
    input  logic        bus_read,
    output logic        cs_rom,
    output logic        cs_dram,
    output logic        cs_io,
    output logic [18:0] rom_addr,
    output logic        map_normal
);

    region_e region;

    boot_remap_mode_flag #(
        .TRIG_ON_READ  (TRIG_ON_READ),
        .TRIG_ON_WRITE (TRIG_ON_WRITE)
    ) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .strobe  (bus_strobe),
        .is_read (bus_read),
        .normal  (map_normal)
    );

    boot_remap_region #(
        .DRAM_BYTES (DRAM_BYTES)
    ) u_region (
        .addr   (bus_addr),
        .normal (map_normal),
        .region (region)
    );

    boot_remap_selects u_sel (
        .region   (region),
        .strobe   (bus_strobe),
        .low_addr (bus_addr[ROM_AW-1:0]),
        .sel_rom  (cs_rom),
        .sel_dram (cs_dram),
        .sel_io   (cs_io),
        .rom_addr (rom_addr)
    );

endmodule

// File: rtl/boot_remap_checker.sv
// Module: assertion checker bound to the decoder top.
// Holds the temporal and exclusivity properties of the decoder.
module boot_remap_checker #(
    parameter logic [31:0] DRAM_BYTES    = 32'h0100_0000,
    parameter bit          TRIG_ON_READ  = 1'b1,
    parameter bit          TRIG_ON_WRITE = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] bus_addr,
    input logic        bus_strobe,
    input logic        bus_read,
    input logic        cs_rom,
    input logic        cs_dram,
    input logic        cs_io,
    input logic [18:0] rom_addr,
    input logic        map_normal
);

    logic trig_hit;
    assign trig_hit = bus_strobe && (bus_addr == 32'hFFFF_8000) &&
                      ((bus_read && TRIG_ON_READ) || (!bus_read && TRIG_ON_WRITE));

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_rom, cs_dram, cs_io})); // R11
    AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |-> !(cs_rom || cs_dram || cs_io)); // R9
    AST_OVERLAY_NO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        !map_normal |-> !cs_dram); // R3
    AST_TRIGGER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |=> map_normal); // R4
    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        map_normal |=> map_normal); // R5
    AST_TOP_IS_IO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_addr[31:15] == 17'h1FFFF) |-> cs_io); // R8
    AST_ROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (map_normal && cs_rom) |-> (bus_addr[31:24] == 8'hFE)); // R6
    AST_DRAM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_dram |-> (bus_addr < DRAM_BYTES)); // R7
    AST_ROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rom |-> (rom_addr == bus_addr[18:0])); // R10

endmodule

bind boot_remap_decoder boot_remap_checker #(
    .DRAM_BYTES    (DRAM_BYTES),
    .TRIG_ON_READ  (TRIG_ON_READ),
    .TRIG_ON_WRITE (TRIG_ON_WRITE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_strobe (bus_strobe),
    .bus_read   (bus_read),
    .cs_rom     (cs_rom),
    .cs_dram    (cs_dram),
    .cs_io      (cs_io),
    .rom_addr   (rom_addr),
    .map_normal (map_normal)
);

// File: tb/tb_boot_remap_decoder.sv
// Bench: random and directed addresses checked against a bench-side model.
module tb_boot_remap_decoder;

    localparam logic [31:0] DRAM_SZ = 32'h0080_0000;
    localparam logic [31:0] TRIG    = 32'hFFFF_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_strobe = 1'b0;
    logic        bus_read = 1'b1;
    logic        cs_rom, cs_dram, cs_io, map_normal;
    logic [18:0] rom_addr;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  model_normal = 1'b0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    boot_remap_decoder #(.DRAM_BYTES(DRAM_SZ)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
        .bus_read(bus_read), .cs_rom(cs_rom), .cs_dram(cs_dram), .cs_io(cs_io),
        .rom_addr(rom_addr), .map_normal(map_normal)
    );

    // Expected {rom, dram, io} from the requirements.
    function automatic logic [2:0] exp_sel(logic [31:0] a, logic s, bit nm);
        if (!s) return 3'b000;                              // R9
        if (a >= 32'hFFFF_8000) return 3'b001;              // R8
        if (!nm) return 3'b100;                             // R2
        if (a[31:24] == 8'hFE) return 3'b100;               // R6
        if (a < DRAM_SZ) return 3'b010;                     // R7
        return 3'b000;                                      // R12
    endfunction

    function automatic string tag_of(logic [31:0] a, logic s, bit nm);
        if (!s) return "R9";
        if (a >= 32'hFFFF_8000) return "R8";
        if (!nm) return "R2/R3";
        if (a[31:24] == 8'hFE) return "R6";
        if (a < DRAM_SZ) return "R7";
        return "R12";
    endfunction

    task automatic check_mode(string tag);
        n_vec++;
        if (map_normal !== model_normal) begin
            n_fail++;
            $display("FAIL %s mode: got %0b expected %0b", tag, map_normal, model_normal);
        end
    endtask

    // Drive one access at the falling edge, compare, then let the edge pass.
    task automatic access(logic [31:0] a, logic s, logic rd);
        logic [2:0]  es;
        logic [18:0] ea;
        @(negedge clk);
        bus_addr = a; bus_strobe = s; bus_read = rd;
        #1;
        es = exp_sel(a, s, model_normal);
        ea = es[2] ? a[18:0] : 19'd0;
        n_vec++;
        if ({cs_rom, cs_dram, cs_io} !== es) begin
            n_fail++;
            $display("FAIL %s sel@%08h: got %03b expected %03b", tag_of(a, s, model_normal),
                     a, {cs_rom, cs_dram, cs_io}, es);
        end
        n_vec++;
        if (rom_addr !== ea) begin
            n_fail++;
            $display("FAIL R10 rom_addr@%08h: got %05h expected %05h", a, rom_addr, ea);
        end
        @(posedge clk);
        if (rst_n && s && a == TRIG) model_normal = 1'b1;   // R4
        #1;
        check_mode("R4/R5");
    endtask

    function automatic logic [31:0] pick_addr();
        logic [31:0] r = $urandom;
        case ($urandom % 6)
            0: return r % DRAM_SZ;
            1: return DRAM_SZ - 32'd4 + (r % 8);
            2: return {8'hFE, r[23:0]};
            3: return {17'h1FFFF, r[14:0]};
            4: return 32'hFDFF_FFF8 + (r % 16);
            default: return r;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_strobe = 1'b0;
        repeat (3) @(posedge clk);
        model_normal = 1'b0;
        #1;
        check_mode("R1");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_mode("R1");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R3 at zero in overlay mode, plus top boundary edges
        access(32'h0000_0000, 1, 1);
        access(32'hFFFF_7FFF, 1, 1);
        access(32'hFFFF_FFFF, 1, 0);
        access(32'hFEFF_FFFF, 1, 1);
        // R4: near misses must not leave overlay mode
        access(TRIG, 0, 0);
        access(32'hFFFF_8004, 1, 0);
        access(32'hFFFF_7FFF, 1, 0);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a = pick_addr();
            if (a == TRIG) a = 32'h0000_1000;
            access(a, 1'($urandom % 4 != 0), 1'($urandom % 2));
        end
        // R4 trigger with a write
        access(TRIG, 1, 0);
        // R6, R7, R12 boundaries in normal mode
        access(32'h0000_0000, 1, 1);
        access(DRAM_SZ - 1, 1, 1);
        access(DRAM_SZ, 1, 1);
        access(32'hFDFF_FFFF, 1, 1);
        access(32'hFE00_0000, 1, 1);
        access(32'hFE08_0123, 1, 1);
        access(32'hFEFF_FFFF, 1, 1);
        access(32'hFF00_0000, 1, 1);
        access(32'hFFFF_7FFF, 1, 1);
        access(TRIG, 1, 1);
        for (int i = 0; i < 600; i++) begin
            access(pick_addr(), 1'($urandom % 4 != 0), 1'($urandom % 2));
        end
        // R1 again, then R4 trigger with a read
        do_reset();
        access(32'h0000_0010, 1, 1);
        access(TRIG, 1, 1);
        access(32'h0000_0010, 1, 1);
        access(32'hFE00_0010, 0, 1);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule